// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Bus

This block collects up to 32 interrupt lines into a single request to a processor. Each line is configured at build time as either edge-triggered (a rising transition) or level-triggered. Captured events are held in a status register until software clears them by writing ones to an acknowledge location. The status is combined with a per-line enable register to form a pending word. A vector location returns the lowest-numbered pending line, which gives line 0 the highest priority.

Software reaches the block through a plain 32-bit register bus with an address, a write strobe, write data and combinational read data. Enable bits can be changed one at a time through separate set and clear locations, so no read-modify-write is needed. A two-bit master control register gates the request output: both a global enable and a hardware-output enable must be on.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the status, enable and master registers read 0, `irq_req` is 0 and the vector location reads 0xFFFFFFFF.
- R2: Byte offsets are: status 0x00, pending 0x04, enable 0x08 (read/write, a write replaces every bit), acknowledge 0x0C, set-enable 0x10, clear-enable 0x14, vector 0x18, master 0x1C. The three write-only locations (0x0C, 0x10, 0x14) read 0.
- R3: A line whose bit in `EDGE_MASK` is 0 is level-triggered. Its status bit is set while the line is high. An acknowledge of that bit clears it for exactly one cycle, and it sets again on the next cycle if the line is still high.
- R4: A line whose bit in `EDGE_MASK` is 1 is edge-triggered. Its status bit is set by a low-to-high transition and stays set after the line falls. Once acknowledged, it stays clear while the line stays high until the next rising transition.
- R5: Writing a mask to set-enable ORs it into the enable register. Writing a mask to clear-enable clears exactly the masked bits. No other enable bit changes.
- R6: Writing a mask to acknowledge clears the matching status bits. Writing 0xFFFFFFFF clears every bit that has no new event in that cycle.
- R7: If an edge event and an acknowledge of the same bit occur in the same cycle, the bit stays set.
- R8: The pending location reads status AND enable.
- R9: The vector location reads the index of the lowest-numbered pending bit, or 0xFFFFFFFF when no bit is pending.
- R10: Master register bit 0 is the global enable and bit 1 the hardware-output enable. Bits [1:0] read back as written and the upper bits read 0. `irq_req` is 1 only when both bits are 1 and at least one bit is pending.
- R11: Timing: a line change reaches the status register on the second rising clock edge after it is applied. `irq_req` follows the gated pending OR one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register access |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_in | input | N_SRC | Interrupt lines |
| irq_req | output | 1 | Registered interrupt request to the processor |

## Verification
Two operations can fall in the same cycle on one status bit: a freshly detected rising edge and a software acknowledge of that bit. The bench provokes this by raising an edge-type line so that its detected edge lines up with the clock edge that takes an acknowledge write. It then expects the bit to read back set. In a separate case, an acknowledge with no edge in that cycle must leave the bit clear. The same kind of overlap is exercised on a level-type line, where the acknowledge must win for exactly one cycle before the held level sets the bit again.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned WORD_IDX_W = 3;

  localparam logic [WORD_IDX_W-1:0] REG_STATUS = 3'd0;
  localparam logic [WORD_IDX_W-1:0] REG_PEND   = 3'd1;
  localparam logic [WORD_IDX_W-1:0] REG_ENABLE = 3'd2;
  localparam logic [WORD_IDX_W-1:0] REG_ACK    = 3'd3;
  localparam logic [WORD_IDX_W-1:0] REG_SETEN  = 3'd4;
  localparam logic [WORD_IDX_W-1:0] REG_CLREN  = 3'd5;
  localparam logic [WORD_IDX_W-1:0] REG_VECTOR = 3'd6;
  localparam logic [WORD_IDX_W-1:0] REG_MASTER = 3'd7;

  localparam logic [31:0] NO_VECTOR = 32'hFFFF_FFFF;

  typedef struct packed {
    logic hw_out_en;
    logic global_en;
  } master_t;

  // Index of the lowest set bit, or all ones when none is set.
  function automatic logic [31:0] lowest_index(input logic [31:0] v);
    logic [31:0] res;
    res = NO_VECTOR;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) res = 32'(i);
    end
    return res;
  endfunction

  // Enable update for the three writable enable views.
  function automatic logic [31:0] next_enable(input logic [31:0] cur,
                                              input logic [31:0] wd,
                                              input logic        wr_full,
                                              input logic        wr_set,
                                              input logic        wr_clr);
    logic [31:0] res;
    res = cur;
    if (wr_full) res = wd;
    if (wr_set)  res = cur | wd;
    if (wr_clr)  res = cur & ~wd;
    return res;
  endfunction
endpackage

// File: rtl/vic_sense.sv
module vic_sense #(
  parameter int unsigned N_SRC     = 8,
  parameter logic [31:0] EDGE_MASK = 32'h0000_00F0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_in,
  output logic [N_SRC-1:0] edge_evt,
  output logic [N_SRC-1:0] level_act
);
  logic [N_SRC-1:0] samp_q;
  logic [N_SRC-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      prev_q <= '0;
    end else begin
      samp_q <= irq_in;
      prev_q <= samp_q;
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_line
    if (EDGE_MASK[g]) begin : g_edge
      assign edge_evt[g]  = samp_q[g] & ~prev_q[g];
      assign level_act[g] = 1'b0;
    end else begin : g_level
      assign edge_evt[g]  = 1'b0;
      assign level_act[g] = samp_q[g];
    end
  end
endmodule

// File: rtl/vic_regfile.sv
module vic_regfile
  import vic_pkg::*;
#(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       bus_addr,
  input  logic             bus_we,
  input  logic [31:0]      bus_wdata,
  input  logic [N_SRC-1:0] edge_evt,
  input  logic [N_SRC-1:0] level_act,
  output logic [N_SRC-1:0] status_q,
  output logic [N_SRC-1:0] enable_q,
  output master_t          master_q,
  output logic             wr_ack,
  output logic             wr_set,
  output logic             wr_clr
);
  logic [WORD_IDX_W-1:0] widx;
  logic                  wr_en_full;
  logic                  wr_master;
  logic [N_SRC-1:0]      ack_mask;
  logic [N_SRC-1:0]      status_d;
  logic [31:0]           enable_d32;

  assign widx       = bus_addr[4:2];
  assign wr_ack     = bus_we && (widx == REG_ACK);
  assign wr_set     = bus_we && (widx == REG_SETEN);
  assign wr_clr     = bus_we && (widx == REG_CLREN);
  assign wr_en_full = bus_we && (widx == REG_ENABLE);
  assign wr_master  = bus_we && (widx == REG_MASTER);

  assign ack_mask   = wr_ack ? bus_wdata[N_SRC-1:0] : '0;

  // Edge events beat a same-cycle acknowledge; a held level is
  // suppressed for the acknowledge cycle and returns on the next one.
  assign status_d   = edge_evt | (level_act & ~ack_mask) | (status_q & ~ack_mask);

  assign enable_d32 = next_enable(32'(enable_q), bus_wdata,
                                  wr_en_full, wr_set, wr_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      master_q <= '0;
    end else begin
      status_q <= status_d;
      enable_q <= enable_d32[N_SRC-1:0];
      if (wr_master) master_q <= master_t'(bus_wdata[1:0]);
    end
  end
endmodule

// File: rtl/vic_vector.sv
module vic_vector
  import vic_pkg::*;
#(
  parameter int unsigned N_SRC = 8
) (
  input  logic [N_SRC-1:0] status_q,
  input  logic [N_SRC-1:0] enable_q,
  input  master_t          master_q,
  output logic [N_SRC-1:0] pend,
  output logic [31:0]      vector,
  output logic             req_d
);
  assign pend   = status_q & enable_q;
  assign vector = lowest_index(32'(pend));
  assign req_d  = (|pend) && master_q.global_en && master_q.hw_out_en;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned N_SRC     = 8,
  parameter logic [31:0] EDGE_MASK = 32'h0000_00F0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       bus_addr,
  input  logic             bus_we,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [N_SRC-1:0] irq_in,
  output logic             irq_req
);
  logic [N_SRC-1:0] edge_evt;
  logic [N_SRC-1:0] level_act;
  logic [N_SRC-1:0] status_q;
  logic [N_SRC-1:0] enable_q;
  master_t          master_q;
  logic             wr_ack;
  logic             wr_set;
  logic             wr_clr;
  logic [N_SRC-1:0] pend;
  logic [31:0]      vector;
  logic             req_d;
  logic             req_q;

  vic_sense #(.N_SRC(N_SRC), .EDGE_MASK(EDGE_MASK)) u_sense (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .edge_evt(edge_evt), .level_act(level_act)
  );

  vic_regfile #(.N_SRC(N_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .edge_evt(edge_evt), .level_act(level_act),
    .status_q(status_q), .enable_q(enable_q), .master_q(master_q),
    .wr_ack(wr_ack), .wr_set(wr_set), .wr_clr(wr_clr)
  );

  vic_vector #(.N_SRC(N_SRC)) u_vec (
    .status_q(status_q), .enable_q(enable_q), .master_q(master_q),
    .pend(pend), .vector(vector), .req_d(req_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end
  assign irq_req = req_q;

  always_comb begin
    unique case (bus_addr[4:2])
      REG_STATUS: bus_rdata = 32'(status_q);
      REG_PEND:   bus_rdata = 32'(pend);
      REG_ENABLE: bus_rdata = 32'(enable_q);
      REG_VECTOR: bus_rdata = vector;
      REG_MASTER: bus_rdata = 32'(master_q);
      default:    bus_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/irq_vector_ctrl_checker.sv
module irq_vector_ctrl_checker #(
  parameter int unsigned N_SRC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      bus_wdata,
  input logic [N_SRC-1:0] edge_evt,
  input logic [N_SRC-1:0] status_q,
  input logic [N_SRC-1:0] enable_q,
  input logic [1:0]       master_bits,
  input logic             wr_ack,
  input logic             wr_set,
  input logic             wr_clr,
  input logic [N_SRC-1:0] pend,
  input logic [31:0]      vector,
  input logic             irq_req
);
  assert_seten_or_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> enable_q == ($past(enable_q) | $past(bus_wdata[N_SRC-1:0])));

  assert_clren_and_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> enable_q == ($past(enable_q) & ~$past(bus_wdata[N_SRC-1:0])));

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> (status_q & $past(bus_wdata[N_SRC-1:0]) & ~$past(edge_evt)) == '0);

  assert_edge_beats_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> (status_q & $past(edge_evt)) == $past(edge_evt));

  assert_vec_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> (vector == 32'hFFFF_FFFF));

  assert_vec_points_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0) |-> ((32'(pend) >> vector[4:0]) & 32'h1) == 32'h1);

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ($past(master_bits) == 2'b11) && ($past(pend) != '0));

  assert_irq_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(master_bits) == 2'b11 && $past(pend) != '0) |-> irq_req);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_checker #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .edge_evt(edge_evt),
  .status_q(status_q), .enable_q(enable_q), .master_bits(2'(master_q)),
  .wr_ack(wr_ack), .wr_set(wr_set), .wr_clr(wr_clr), .pend(pend),
  .vector(vector), .irq_req(irq_req)
);

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  localparam logic [4:0] A_STAT = 5'h00, A_PEND = 5'h04, A_EN = 5'h08,
                         A_ACK = 5'h0C, A_SET = 5'h10, A_CLR = 5'h14,
                         A_VEC = 5'h18, A_MST = 5'h1C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  irq_in = '0;
  logic          irq_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  irq_vector_ctrl #(.N_SRC(N), .EDGE_MASK(32'h0000_00F0)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .irq_req(irq_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // All tasks start and end at a falling edge.
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_reg(input string req, input logic [4:0] a,
                           input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset();
    check_reg("R1 status", A_STAT, 32'h0);
    check_reg("R1 enable", A_EN, 32'h0);
    check_reg("R1 master", A_MST, 32'h0);
    check_reg("R1 vector", A_VEC, 32'hFFFF_FFFF);
    check("R1 irq_req", 32'(irq_req), 32'h0);
  endtask

  task automatic t_enable_ops();
    wr(A_EN, 32'h0000_0011);
    check_reg("R2 enable write", A_EN, 32'h11);
    wr(A_SET, 32'h0000_0006);
    check_reg("R5 set-enable", A_EN, 32'h17);
    wr(A_CLR, 32'h0000_0011);
    check_reg("R5 clear-enable", A_EN, 32'h06);
    check_reg("R2 set reads 0", A_SET, 32'h0);
    check_reg("R2 clear reads 0", A_CLR, 32'h0);
    wr(A_EN, 32'h0);
    check_reg("R2 enable zero", A_EN, 32'h0);
  endtask

  task automatic t_timing_level();
    irq_in[1] = 1'b1;
    tick(1);
    check_reg("R11 not yet after one edge", A_STAT, 32'h0);
    tick(1);
    check_reg("R11 status after two edges", A_STAT, 32'h02);
    wr(A_ACK, 32'h2);
    check_reg("R3 level cleared one cycle", A_STAT, 32'h0);
    tick(1);
    check_reg("R3 level re-set", A_STAT, 32'h02);
    irq_in[1] = 1'b0;
    tick(2);
    wr(A_ACK, 32'h2);
    check_reg("R3 level stays clear when low", A_STAT, 32'h0);
  endtask

  task automatic t_edge();
    irq_in[5] = 1'b1;
    tick(2);
    check_reg("R4 edge set", A_STAT, 32'h20);
    irq_in[5] = 1'b0;
    tick(2);
    check_reg("R4 edge held after fall", A_STAT, 32'h20);
    irq_in[5] = 1'b1;
    tick(3);
    wr(A_ACK, 32'h20);
    tick(2);
    check_reg("R4 edge clear while high", A_STAT, 32'h0);
    irq_in[5] = 1'b0;
    tick(2);
  endtask

  task automatic t_collision();
    irq_in[4] = 1'b1;
    tick(1);
    wr(A_ACK, 32'h10);
    check_reg("R7 edge beats ack", A_STAT, 32'h10);
    wr(A_ACK, 32'h10);
    check_reg("R7 later ack clears", A_STAT, 32'h0);
    irq_in[4] = 1'b0;
    tick(2);
  endtask

  task automatic t_vector_irq();
    irq_in[2] = 1'b1;
    irq_in[6] = 1'b1;
    tick(2);
    irq_in[6] = 1'b0;
    check_reg("R8 pending none enabled", A_PEND, 32'h0);
    check_reg("R9 vector empty", A_VEC, 32'hFFFF_FFFF);
    wr(A_EN, 32'h44);
    check_reg("R8 pending", A_PEND, 32'h44);
    check_reg("R9 lowest index", A_VEC, 32'd2);
    wr(A_MST, 32'hFFFF_FFFD);
    check_reg("R10 master readback", A_MST, 32'h1);
    tick(2);
    check("R10 one master bit blocks", 32'(irq_req), 32'h0);
    wr(A_MST, 32'h3);
    check("R11 irq one edge later", 32'(irq_req), 32'h0);
    tick(1);
    check("R10 irq asserted", 32'(irq_req), 32'h1);
    wr(A_CLR, 32'h04);
    check_reg("R9 next index", A_VEC, 32'd6);
    irq_in[2] = 1'b0;
    tick(1);
    wr(A_ACK, 32'hFFFF_FFFF);
    check_reg("R6 ack all", A_STAT, 32'h0);
    tick(1);
    check("R10 irq drops", 32'(irq_req), 32'h0);
    check_reg("R9 vector empty again", A_VEC, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick(1);
    t_enable_ops();
    t_timing_level();
    t_edge();
    t_collision();
    t_vector_irq();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule